// File: doc/BRIEF.md
# Reset and Boot Configuration Sequencer

This block takes a device out of reset and loads its configuration. It combines an internal power-on reset with an active-low external reset pin. While either one is active, it holds the rest of the device in a defined default state. Once both have cleared, it fetches a fixed leading block of configuration words from on-chip one-time-programmable memory and writes them into the register bank.

One of those leading words carries a two-bit boot selector. The selector decides where the remaining words come from: more OTP memory, an external serial EEPROM reached through an I2C master engine, or OTP followed by EEPROM, so that the EEPROM copy wins. The OTP reader and the EEPROM engine sit outside this block. Each is driven through its own request/acknowledge port that moves one word per handshake.

When loading ends, the sequencer opens the serial slave port and sends a one-cycle start request to the PLL. If the EEPROM refuses a word or stays silent for too long, a sticky error flag is set. Boot then finishes with whatever values have already been written.

Top module: `boot_seq_ctrl`

## Requirements
- R1: `dev_rst_o` is high while `por_i` is high or `ext_rst_n_i` is low. It falls on the second rising clock edge after the later of the two releases.
- R2: A low pulse on `ext_rst_n_i` of 10 ns or more, even one shorter than a clock period, raises `dev_rst_o` at once without waiting for a clock edge. The boot is then restarted from the beginning.
- R3: While `dev_rst_o` is high, `slave_en_o`, `pll_start_o`, `boot_err_o`, `otp_req_o`, `ee_req_o` and `cfg_we_o` are all low. The register bank, the interrupt status and enable bits, the clock output enables and the GPIO direction select all take `dev_rst_o` as their return-to-default control.
- R4: After reset, OTP words 0 to INIT_LEN-1 (default 4) are written in ascending order to the register addresses of the same numbers. This always happens before any other load.
- R5: The boot selector is bits [1:0] of the OTP word at address BOOT_ADDR (default 2) of the leading block. Its codes are: 00 = OTP remainder only, 01 = EEPROM remainder only, 10 = OTP remainder then EEPROM remainder, 11 = same as 00.
- R6: The OTP remainder writes OTP words INIT_LEN to TOTAL_LEN-1 (default 4 to 11) to the register addresses of the same numbers, in ascending order.
- R7: The EEPROM remainder requests EEPROM word i (i = 0 to TOTAL_LEN-INIT_LEN-1) and writes it to register INIT_LEN+i, in ascending order.
- R8: `slave_en_o` rises in the cycle after the final configuration write. `pll_start_o` is high for exactly that one cycle. After that, `slave_en_o` stays high and no further requests or writes occur until the next reset.
- R9: `ee_nack_i` during an EEPROM request sets `boot_err_o` and ends the boot at once. That word is not written, and words loaded earlier are kept.
- R10: An EEPROM request that goes TIMEOUT consecutive cycles (default 65,535) without acknowledge is abandoned in the same way as a NACK.
- R11: `boot_err_o`, once set, stays high until the next reset.
- R12: The two request ports are never high together. A request's address holds steady until that request is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Internal power-on reset, active high |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| otp_req_o | output | 1 | OTP word request |
| otp_addr_o | output | REG_AW | OTP word address |
| otp_ack_i | input | 1 | OTP word valid on `otp_data_i` |
| otp_data_i | input | DW | OTP word data |
| ee_req_o | output | 1 | EEPROM word request to the I2C master engine |
| ee_addr_o | output | EE_AW | EEPROM word offset |
| ee_ack_i | input | 1 | EEPROM word valid on `ee_data_i` |
| ee_nack_i | input | 1 | EEPROM transfer refused |
| ee_data_i | input | DW | EEPROM word data |
| cfg_we_o | output | 1 | Register bank write strobe |
| cfg_waddr_o | output | REG_AW | Register bank write address |
| cfg_wdata_o | output | DW | Register bank write data |
| dev_rst_o | output | 1 | Device reset, holds everything at default |
| slave_en_o | output | 1 | Serial slave port enable |
| pll_start_o | output | 1 | One-cycle PLL lock start request |
| boot_err_o | output | 1 | Sticky EEPROM boot failure flag |

## Verification
Most internal faults show up in the register write stream in the same cycle as the acknowledge that causes them. A wrong state, a miscounted index or a misread selector leaves a write at the wrong address, a missing write, or a request on the wrong port. A stuck or misrouted state also shows up at the gate signals: `slave_en_o` and `pll_start_o` move one cycle after the last write, so any early or late exit is visible one cycle later. A faulty synchronizer changes how many edges pass before `dev_rst_o` falls. A faulty wait counter changes how many cycles an unanswered EEPROM request is held before `boot_err_o` rises.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_INIT     = 3'd1,
    ST_OTP_REST = 3'd2,
    ST_EE_REST  = 3'd3,
    ST_DONE     = 3'd4
  } boot_state_e;

  typedef enum logic [1:0] {
    BM_OTP  = 2'b00,
    BM_EE   = 2'b01,
    BM_BOTH = 2'b10,
    BM_RSVD = 2'b11
  } boot_mode_e;

  // Phase that follows the leading OTP block
  function automatic boot_state_e after_init(input logic [1:0] fld);
    boot_mode_e m;
    m = boot_mode_e'(fld);
    return (m == BM_EE) ? ST_EE_REST : ST_OTP_REST;
  endfunction

  // Phase that follows the OTP remainder
  function automatic boot_state_e after_otp_rest(input logic [1:0] fld);
    boot_mode_e m;
    m = boot_mode_e'(fld);
    return (m == BM_BOTH) ? ST_EE_REST : ST_DONE;
  endfunction

endpackage

// File: rtl/boot_rst_sync.sv
module boot_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic ext_rst_n_i,
  output logic rst_o
);
  logic              raw_rst;
  logic [STAGES-1:0] chain;

  assign raw_rst = por_i | ~ext_rst_n_i;

  // asynchronous entry, release after STAGES edges
  always_ff @(posedge clk_i or posedge raw_rst) begin
    if (raw_rst) chain <= '1;
    else         chain <= {chain[STAGES-2:0], 1'b0};
  end

  assign rst_o = chain[STAGES-1];
endmodule

// File: rtl/boot_xfer_cnt.sv
module boot_xfer_cnt #(
  parameter int LEN = 4,
  parameter int CW  = 3
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          clr_i,
  input  logic          step_i,
  output logic [CW-1:0] idx_o,
  output logic          last_o
);
  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i)       idx_o <= '0;
    else if (clr_i)  idx_o <= '0;
    else if (step_i) idx_o <= idx_o + 1'b1;
  end

  assign last_o = (idx_o == CW'(LEN - 1));
endmodule

// File: rtl/boot_wait_timer.sv
module boot_wait_timer #(
  parameter int LIMIT = 65535,
  parameter int TW    = 16
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic wait_i,
  output logic expire_o
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i)       cnt <= '0;
    else if (wait_i) cnt <= cnt + 1'b1;
    else             cnt <= '0;
  end

  // the LIMIT-th consecutive waiting cycle
  assign expire_o = wait_i && (cnt == TW'(LIMIT - 1));
endmodule

// File: rtl/boot_seq_ctrl.sv
module boot_seq_ctrl
  import boot_seq_pkg::*;
#(
  parameter int REG_AW    = 8,
  parameter int DW        = 8,
  parameter int EE_AW     = 8,
  parameter int INIT_LEN  = 4,
  parameter int TOTAL_LEN = 12,
  parameter int BOOT_ADDR = 2,
  parameter int BOOT_LSB  = 0,
  parameter int TIMEOUT   = 65535
) (
  input  logic              clk_i,
  input  logic              por_i,
  input  logic              ext_rst_n_i,
  output logic              otp_req_o,
  output logic [REG_AW-1:0] otp_addr_o,
  input  logic              otp_ack_i,
  input  logic [DW-1:0]     otp_data_i,
  output logic              ee_req_o,
  output logic [EE_AW-1:0]  ee_addr_o,
  input  logic              ee_ack_i,
  input  logic              ee_nack_i,
  input  logic [DW-1:0]     ee_data_i,
  output logic              cfg_we_o,
  output logic [REG_AW-1:0] cfg_waddr_o,
  output logic [DW-1:0]     cfg_wdata_o,
  output logic              dev_rst_o,
  output logic              slave_en_o,
  output logic              pll_start_o,
  output logic              boot_err_o
);
  localparam int REST_LEN = TOTAL_LEN - INIT_LEN;
  localparam int ICW      = $clog2(INIT_LEN + 1);
  localparam int RCW      = $clog2(REST_LEN + 1);
  localparam int TW       = $clog2(TIMEOUT + 1);

  function automatic logic [REG_AW-1:0] init_addr(input logic [ICW-1:0] i);
    return REG_AW'(i);
  endfunction

  function automatic logic [REG_AW-1:0] rest_addr(input logic [RCW-1:0] i);
    return REG_AW'(INIT_LEN) + REG_AW'(i);
  endfunction

  // named internal events
  logic            rst;
  boot_state_e     st, st_nx;
  logic [1:0]      boot_fld, fld_eff;
  logic [ICW-1:0]  init_idx;
  logic [RCW-1:0]  rest_idx;
  logic            init_last, rest_last;
  logic            otp_hit, ee_hit, ee_fail_evt, ee_tmo, ee_wait;
  logic            boot_hit, phase_chg, rest_step;
  logic            pll_q, err_q;

  boot_rst_sync #(.STAGES(2)) u_rst (
    .clk_i(clk_i), .por_i(por_i), .ext_rst_n_i(ext_rst_n_i), .rst_o(rst)
  );

  boot_xfer_cnt #(.LEN(INIT_LEN), .CW(ICW)) u_init_cnt (
    .clk_i(clk_i), .rst_i(rst), .clr_i(1'b0), .step_i(otp_hit && st == ST_INIT),
    .idx_o(init_idx), .last_o(init_last)
  );

  boot_xfer_cnt #(.LEN(REST_LEN), .CW(RCW)) u_rest_cnt (
    .clk_i(clk_i), .rst_i(rst), .clr_i(phase_chg), .step_i(rest_step),
    .idx_o(rest_idx), .last_o(rest_last)
  );

  boot_wait_timer #(.LIMIT(TIMEOUT), .TW(TW)) u_tmo (
    .clk_i(clk_i), .rst_i(rst), .wait_i(ee_wait), .expire_o(ee_tmo)
  );

  // request ports
  assign otp_req_o  = (st == ST_INIT) || (st == ST_OTP_REST);
  assign otp_addr_o = (st == ST_INIT) ? init_addr(init_idx) : rest_addr(rest_idx);
  assign ee_req_o   = (st == ST_EE_REST);
  assign ee_addr_o  = EE_AW'(rest_idx);

  assign otp_hit     = otp_req_o && otp_ack_i;
  assign ee_hit      = ee_req_o && ee_ack_i && !ee_nack_i;
  assign ee_wait     = ee_req_o && !ee_ack_i && !ee_nack_i;
  assign ee_fail_evt = ee_req_o && (ee_nack_i || ee_tmo);
  assign rest_step   = (otp_hit && st == ST_OTP_REST) || ee_hit;

  // boot selector snooped from the leading block
  assign boot_hit = (st == ST_INIT) && otp_hit && (init_idx == ICW'(BOOT_ADDR));
  assign fld_eff  = boot_hit ? otp_data_i[BOOT_LSB +: 2] : boot_fld;

  always_ff @(posedge clk_i or posedge rst) begin
    if (rst)           boot_fld <= 2'b00;
    else if (boot_hit) boot_fld <= otp_data_i[BOOT_LSB +: 2];
  end

  // register bank write stream
  assign cfg_we_o    = otp_hit || ee_hit;
  assign cfg_waddr_o = (st == ST_INIT) ? init_addr(init_idx) : rest_addr(rest_idx);
  assign cfg_wdata_o = otp_hit ? otp_data_i : ee_data_i;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:     st_nx = ST_INIT;
      ST_INIT:     if (otp_hit && init_last) st_nx = after_init(fld_eff);
      ST_OTP_REST: if (otp_hit && rest_last) st_nx = after_otp_rest(boot_fld);
      ST_EE_REST: begin
        if (ee_fail_evt)             st_nx = ST_DONE;
        else if (ee_hit && rest_last) st_nx = ST_DONE;
      end
      ST_DONE:     st_nx = ST_DONE;
      default:     st_nx = ST_IDLE;
    endcase
  end

  assign phase_chg = (st_nx != st);

  always_ff @(posedge clk_i or posedge rst) begin
    if (rst) begin
      st    <= ST_IDLE;
      pll_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      st    <= st_nx;
      pll_q <= (st_nx == ST_DONE) && (st != ST_DONE);
      err_q <= err_q | ee_fail_evt;
    end
  end

  assign dev_rst_o   = rst;
  assign slave_en_o  = (st == ST_DONE);
  assign pll_start_o = pll_q;
  assign boot_err_o  = err_q;
endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk #(
  parameter int REG_AW = 8,
  parameter int EE_AW  = 8
) (
  input logic              clk_i,
  input logic              dev_rst_o,
  input logic              otp_req_o,
  input logic              otp_ack_i,
  input logic [REG_AW-1:0] otp_addr_o,
  input logic              ee_req_o,
  input logic              ee_ack_i,
  input logic [EE_AW-1:0]  ee_addr_o,
  input logic              ee_fail_evt,
  input logic              cfg_we_o,
  input logic              slave_en_o,
  input logic              pll_start_o,
  input logic              boot_err_o
);
  always @(posedge clk_i) begin
    if (dev_rst_o) begin
      assert_reset_quiet_R3: assert (!slave_en_o && !pll_start_o && !boot_err_o &&
                                     !otp_req_o && !ee_req_o && !cfg_we_o)
        else $error("R3 outputs active during reset");
    end
  end

  assert_one_port_R12: assert property (@(posedge clk_i) disable iff (dev_rst_o)
    !(otp_req_o && ee_req_o));

  assert_otp_addr_hold_R12: assert property (@(posedge clk_i) disable iff (dev_rst_o)
    (otp_req_o && !otp_ack_i) |=> $stable(otp_addr_o));

  assert_ee_addr_hold_R12: assert property (@(posedge clk_i) disable iff (dev_rst_o)
    (ee_req_o && !ee_ack_i && !ee_fail_evt) |=> $stable(ee_addr_o));

  assert_pll_with_gate_R8: assert property (@(posedge clk_i) disable iff (dev_rst_o)
    $rose(slave_en_o) |-> pll_start_o);

  assert_pll_single_R8: assert property (@(posedge clk_i) disable iff (dev_rst_o)
    pll_start_o |=> !pll_start_o);

  assert_gate_holds_R8: assert property (@(posedge clk_i) disable iff (dev_rst_o)
    slave_en_o |=> slave_en_o);

  assert_quiet_after_done_R8: assert property (@(posedge clk_i) disable iff (dev_rst_o)
    slave_en_o |-> (!cfg_we_o && !otp_req_o && !ee_req_o));

  assert_fail_ends_R9: assert property (@(posedge clk_i) disable iff (dev_rst_o)
    ee_fail_evt |=> (boot_err_o && slave_en_o));

  assert_err_sticky_R11: assert property (@(posedge clk_i) disable iff (dev_rst_o)
    boot_err_o |=> boot_err_o);
endmodule

bind boot_seq_ctrl boot_seq_chk #(.REG_AW(REG_AW), .EE_AW(EE_AW)) u_chk (
  .clk_i(clk_i), .dev_rst_o(dev_rst_o),
  .otp_req_o(otp_req_o), .otp_ack_i(otp_ack_i), .otp_addr_o(otp_addr_o),
  .ee_req_o(ee_req_o), .ee_ack_i(ee_ack_i), .ee_addr_o(ee_addr_o),
  .ee_fail_evt(ee_fail_evt), .cfg_we_o(cfg_we_o), .slave_en_o(slave_en_o),
  .pll_start_o(pll_start_o), .boot_err_o(boot_err_o)
);

// File: tb/boot_seq_ctrl_bench.sv
module boot_seq_ctrl_bench;
  localparam int TMO = 200;

  logic       clk = 0;
  logic       por_i = 0, ext_rst_n_i = 1;
  logic       otp_req_o, otp_ack_i = 0;
  logic [7:0] otp_addr_o, otp_data_i = 0;
  logic       ee_req_o, ee_ack_i = 0, ee_nack_i = 0;
  logic [7:0] ee_addr_o, ee_data_i = 0;
  logic       cfg_we_o;
  logic [7:0] cfg_waddr_o, cfg_wdata_o;
  logic       dev_rst_o, slave_en_o, pll_start_o, boot_err_o;

  always #4 clk = ~clk;

  boot_seq_ctrl #(.TIMEOUT(TMO)) u_boot_seq_ctrl (
    .clk_i(clk), .por_i(por_i), .ext_rst_n_i(ext_rst_n_i),
    .otp_req_o(otp_req_o), .otp_addr_o(otp_addr_o), .otp_ack_i(otp_ack_i), .otp_data_i(otp_data_i),
    .ee_req_o(ee_req_o), .ee_addr_o(ee_addr_o), .ee_ack_i(ee_ack_i), .ee_nack_i(ee_nack_i),
    .ee_data_i(ee_data_i), .cfg_we_o(cfg_we_o), .cfg_waddr_o(cfg_waddr_o), .cfg_wdata_o(cfg_wdata_o),
    .dev_rst_o(dev_rst_o), .slave_en_o(slave_en_o), .pll_start_o(pll_start_o), .boot_err_o(boot_err_o)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] otp_mem [16];
  logic [7:0] ee_mem  [8];
  int la [32];
  int ld [32];
  int nlog, lastw, slave_cyc, ee_cycles;
  bit otp_rest_seen, both_high, pll_at;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_mode(input int mode);
    for (int i = 0; i < 16; i++) otp_mem[i] = 8'(8'h30 + i);
    otp_mem[2] = {6'b101010, 2'(mode)};
    for (int i = 0; i < 8; i++) ee_mem[i] = 8'(8'hA0 + i);
  endtask

  task automatic check_reset_state(input string tag);
    chk(dev_rst_o == 1, {tag, " R1 dev_rst high"}, dev_rst_o, 1);
    chk({slave_en_o, pll_start_o, boot_err_o, otp_req_o, ee_req_o, cfg_we_o} == 6'b0,
        {tag, " R3 outputs quiet in reset"},
        {slave_en_o, pll_start_o, boot_err_o, otp_req_o, ee_req_o, cfg_we_o}, 0);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    ext_rst_n_i = 0;
    repeat (3) @(negedge clk);
    check_reset_state("ext");
    ext_rst_n_i = 1;
    @(negedge clk);
    chk(dev_rst_o == 1, "R1 still in reset after one edge", dev_rst_o, 1);
    @(negedge clk);
    chk(dev_rst_o == 0, "R1 released after two edges", dev_rst_o, 0);
  endtask

  // kind: 0 = EEPROM answers, 1 = NACK at word k, 2 = silence at word k
  task automatic run_boot(input bit gap, input int kind, input int k);
    nlog = 0; lastw = -1; slave_cyc = -1; ee_cycles = 0;
    otp_rest_seen = 0; both_high = 0;
    for (int t = 0; t < 2000; t++) begin
      if (slave_en_o) begin slave_cyc = t; break; end
      otp_ack_i  = otp_req_o && (!gap || (t % 2 == 1));
      otp_data_i = otp_mem[otp_addr_o[3:0]];
      ee_ack_i = 0; ee_nack_i = 0;
      if (ee_req_o) begin
        ee_cycles++;
        ee_data_i = ee_mem[ee_addr_o[2:0]];
        if (int'(ee_addr_o) == k && kind == 1) ee_nack_i = 1;
        else if (!(int'(ee_addr_o) == k && kind == 2)) ee_ack_i = 1;
      end
      if (otp_req_o && otp_addr_o >= 8'd4) otp_rest_seen = 1;
      if (otp_req_o && ee_req_o) both_high = 1;
      #1;
      if (cfg_we_o) begin
        la[nlog] = int'(cfg_waddr_o); ld[nlog] = int'(cfg_wdata_o);
        nlog++; lastw = t;
      end
      @(negedge clk);
    end
    pll_at = pll_start_o;
    otp_ack_i = 0; ee_ack_i = 0; ee_nack_i = 0;
  endtask

  task automatic check_log(input int kind, input int k, input string tag);
    int ea [32];
    int ed [32];
    int n = 0, bad = 0, first = -1;
    int f = int'(otp_mem[2][1:0]);
    bit do_otp = (f != 1);
    bit do_ee = (f == 1 || f == 2);
    int lim = (kind == 0) ? 8 : k;
    for (int i = 0; i < 4; i++) begin ea[n] = i; ed[n] = int'(otp_mem[i]); n++; end
    if (do_otp) for (int i = 4; i < 12; i++) begin ea[n] = i; ed[n] = int'(otp_mem[i]); n++; end
    if (do_ee) for (int i = 0; i < lim; i++) begin ea[n] = 4 + i; ed[n] = int'(ee_mem[i]); n++; end
    chk(nlog == n, {tag, " write count"}, nlog, n);
    for (int i = 0; i < n && i < nlog; i++)
      if (la[i] != ea[i] || ld[i] != ed[i]) begin bad++; if (first < 0) first = i; end
    if (first >= 0) chk(0, {tag, " write stream"}, la[first] * 256 + ld[first], ea[first] * 256 + ed[first]);
    else chk(1, {tag, " write stream"}, 0, 0);
    chk(boot_err_o == (do_ee && kind != 0), {tag, " R9 R10 boot_err"}, boot_err_o, do_ee && kind != 0);
    chk(slave_cyc >= 0 && pll_at == 1, {tag, " R8 gate and pll start"}, pll_at, 1);
    chk(!both_high, {tag, " R12 one port at a time"}, both_high, 0);
    if (kind == 0) chk(slave_cyc == lastw + 1, {tag, " R8 gate cycle"}, slave_cyc, lastw + 1);
    @(negedge clk);
    chk(pll_start_o == 0 && slave_en_o == 1, {tag, " R8 pll one cycle, gate held"},
        {pll_start_o, slave_en_o}, 1);
  endtask

  task automatic t_por_later();
    por_i = 1; ext_rst_n_i = 0;
    repeat (2) @(negedge clk);
    check_reset_state("por");
    ext_rst_n_i = 1;
    repeat (5) @(negedge clk);
    chk(dev_rst_o == 1, "R1 por still holds reset", dev_rst_o, 1);
    set_mode(0);
    por_i = 0;
    @(negedge clk);
    chk(dev_rst_o == 1, "R1 por release one edge", dev_rst_o, 1);
    @(negedge clk);
    chk(dev_rst_o == 0, "R1 por release two edges", dev_rst_o, 0);
    run_boot(0, 0, 0);
    check_log(0, 0, "R4 R6 boot after por");
  endtask

  task automatic t_mode_otp();
    set_mode(0); apply_reset(); run_boot(0, 0, 0);
    chk(!otp_rest_seen || nlog == 12, "R5 mode 00 uses OTP", nlog, 12);
    check_log(0, 0, "R6 mode 00");
  endtask

  task automatic t_mode_ee();
    set_mode(1); apply_reset(); run_boot(0, 0, 0);
    chk(otp_rest_seen == 0, "R5 mode 01 skips OTP remainder", otp_rest_seen, 0);
    check_log(0, 0, "R7 mode 01");
  endtask

  task automatic t_mode_both_gap();
    set_mode(2); apply_reset(); run_boot(1, 0, 0);
    check_log(0, 0, "R5 R12 mode 10 slow OTP");
  endtask

  task automatic t_mode_rsvd();
    set_mode(3); apply_reset(); run_boot(0, 0, 0);
    chk(ee_cycles == 0, "R5 mode 11 no EEPROM", ee_cycles, 0);
    check_log(0, 0, "R5 mode 11");
  endtask

  task automatic t_ee_nack();
    set_mode(2); apply_reset(); run_boot(0, 1, 3);
    chk(ee_cycles == 4, "R9 nack ends at word 3", ee_cycles, 4);
    check_log(1, 3, "R9 nack");
    repeat (10) @(negedge clk);
    chk(boot_err_o == 1 && slave_en_o == 1, "R11 error sticky", boot_err_o, 1);
  endtask

  task automatic t_ee_timeout();
    set_mode(1); apply_reset(); run_boot(0, 2, 2);
    chk(ee_cycles == 2 + TMO, "R10 wait window length", ee_cycles, 2 + TMO);
    check_log(2, 2, "R10 timeout");
  endtask

  task automatic t_short_pulse();
    set_mode(0); apply_reset(); run_boot(0, 0, 0);
    chk(slave_en_o == 1, "R2 booted before pulse", slave_en_o, 1);
    @(negedge clk);
    #1 ext_rst_n_i = 0;
    #1;
    chk(dev_rst_o == 1 && slave_en_o == 0, "R2 async entry", {dev_rst_o, slave_en_o}, 2);
    #9 ext_rst_n_i = 1;
    for (int i = 0; i < 5 && dev_rst_o; i++) @(negedge clk);
    chk(dev_rst_o == 0 && boot_err_o == 0, "R2 released after pulse", dev_rst_o, 0);
    run_boot(0, 0, 0);
    check_log(0, 0, "R2 reboot");
  endtask

  initial begin
    #1 por_i = 1;
    t_por_later();
    t_mode_otp();
    t_mode_ee();
    t_mode_both_gap();
    t_mode_rsvd();
    t_ee_nack();
    t_ee_timeout();
    t_short_pulse();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule